// File: doc/BRIEF.md
# Fatal Link-Down Containment Controller

This block watches the data-link state of a four-lane chip-to-chip link and turns a loss of that link into a contained, permanent failure. Until the link has come up for the first time, link-down is normal training and is ignored. Once the link has been up, the first drop latches a fatal state that only reset clears. From then on the block holds retraining off and stops every completion from travelling upstream. It also raises the single error signal it is allowed to use, a system-error pulse attributed to the host bridge function (device 0).

Non-posted downstream requests are tracked by tag in a scoreboard while the link is healthy. A completion is forwarded upstream only when it matches an open tag. When the fatal event hits, every tag still open is moved to a dropped set. Later completions for those tags are discarded and flagged as stale. Requests that were already sent are never aborted; only their completions are withheld.

Top module: `link_fatal_guard`

## Requirements
- R1: `width_bad` goes high one cycle after `link_up` is sampled high with `link_width` not equal to 4. A link reported up at any width other than 4 never counts as "having been up".
- R2: A link-down while the link has never been up at width 4 since reset does not make the block fatal, and training may retry freely.
- R3: A cycle with `link_up` low after the link has been up at width 4 sets `fatal` on the next clock edge. `fatal` then stays high until reset, even if `link_up` returns.
- R4: `retrain_block` is high exactly when `fatal` is high.
- R5: If `serr_en` is high in the cycle that causes the fatal event, `serr` is high for exactly one cycle, aligned with the first cycle of `fatal`, and `serr_dev` reads 0. `serr` is never high at any other time. `serr_status` goes high with that pulse and stays high until reset.
- R6: Before the fatal event, a request with `req_valid` and `req_np` high opens its tag. A completion with `cpl_valid` high on an open tag raises `cpl_fwd` for one cycle on the next edge, with `cpl_tag_o` equal to its tag, and closes the tag.
- R7: A completion whose tag is not open, or whose tag was opened only by a posted request (`req_np` low), raises `cpl_drop` instead of `cpl_fwd`.
- R8: From the cycle that causes the fatal event onward, every completion raises `cpl_drop` and never `cpl_fwd`. New requests are not tracked.
- R9: A completion dropped after the fatal event also raises `cpl_stale` if its tag was open at the fatal event. The first such completion clears that tag from the dropped set, so a repeat of the tag is not stale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Data-link-up status from the link layer |
| link_width | input | 5 | Negotiated lane count |
| serr_en | input | 1 | Enables system-error reporting |
| req_valid | input | 1 | Downstream request strobe |
| req_np | input | 1 | Request is non-posted |
| req_tag | input | 5 | Request tag |
| cpl_valid | input | 1 | Upstream completion strobe |
| cpl_tag | input | 5 | Completion tag |
| retrain_block | output | 1 | Holds link retraining off |
| fatal | output | 1 | Sticky fatal link-down state |
| width_bad | output | 1 | Link up at an unsupported width |
| serr | output | 1 | One-cycle system-error pulse |
| serr_dev | output | 5 | Source device number of the error (0) |
| serr_status | output | 1 | Sticky record of a reported error |
| cpl_fwd | output | 1 | Completion forwarded upstream |
| cpl_drop | output | 1 | Completion discarded |
| cpl_stale | output | 1 | Discarded completion belonged to a request open at the fatal event |
| cpl_tag_o | output | 5 | Tag of the completion just handled |

## Verification
A wrong "has been up" bit or fatal latch shows at the ports on the very next edge after the first drop, through `fatal`, `retrain_block` and `serr`. A scoreboard bit set or cleared wrongly stays hidden until a completion for that tag arrives. It then shows one cycle later as `cpl_fwd` swapped for `cpl_drop`, or as a wrong `cpl_stale`. Keeping tags in a small range makes such a completion arrive within a few cycles.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  localparam int unsigned TAG_W   = 5;
  localparam int unsigned WIDTH_W = 5;
  localparam int unsigned DEV_W   = 5;

  typedef struct packed {
    logic           fwd;
    logic           drop;
    logic           stale;
    logic [TAG_W-1:0] tag;
  } cpl_res_t;
endpackage

// File: rtl/lfg_link_monitor.sv
module lfg_link_monitor #(
  parameter int unsigned WIDTH_W   = 5,
  parameter int unsigned REQ_LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_up,
  input  logic [WIDTH_W-1:0] link_width,
  input  logic               serr_en,
  output logic               fatal_next,
  output logic               fatal_q,
  output logic               width_bad_q,
  output logic               serr_q,
  output logic               serr_status_q
);
  localparam logic [WIDTH_W-1:0] GOOD_W = WIDTH_W'(REQ_LANES);

  logic was_up_q;
  logic link_ok;

  assign link_ok    = link_up && (link_width == GOOD_W);
  assign fatal_next = fatal_q || (was_up_q && !link_up);

  always_ff @(posedge clk) begin
    if (rst) begin
      was_up_q      <= 1'b0;
      fatal_q       <= 1'b0;
      width_bad_q   <= 1'b0;
      serr_q        <= 1'b0;
      serr_status_q <= 1'b0;
    end else begin
      was_up_q    <= was_up_q || link_ok;
      fatal_q     <= fatal_next;
      width_bad_q <= link_up && (link_width != GOOD_W);
      serr_q      <= serr_en && fatal_next && !fatal_q;
      if (serr_en && fatal_next && !fatal_q) serr_status_q <= 1'b1;
    end
  end

  a_r2_no_fatal_before_up: assert property (@(posedge clk) disable iff (rst)
    (!was_up_q && !fatal_q) |=> !fatal_q);
  a_r3_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);
  a_r5_serr_single: assert property (@(posedge clk) disable iff (rst)
    serr_q |=> !serr_q);
  a_r5_serr_on_entry: assert property (@(posedge clk) disable iff (rst)
    serr_q |-> (fatal_q && !$past(fatal_q)));
  a_r5_status_sticky: assert property (@(posedge clk) disable iff (rst)
    serr_status_q |=> serr_status_q);
endmodule

// File: rtl/lfg_tag_board.sv
module lfg_tag_board #(
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fatal_next,
  input  logic             fatal_q,
  input  logic             req_valid,
  input  logic             req_np,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  output lfg_pkg::cpl_res_t res_q
);
  localparam int unsigned DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0] open_q, drop_q;
  logic [DEPTH-1:0] drop_view;
  logic             hit_open, hit_drop, fwd_now, stale_now;

  assign drop_view = fatal_q ? drop_q : open_q;
  assign hit_open  = open_q[cpl_tag];
  assign hit_drop  = drop_view[cpl_tag];
  assign fwd_now   = cpl_valid && !fatal_next && hit_open;
  assign stale_now = cpl_valid && fatal_next && hit_drop;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= '0;
      drop_q <= '0;
      res_q  <= '0;
    end else begin
      res_q.fwd   <= fwd_now;
      res_q.drop  <= cpl_valid && !fwd_now;
      res_q.stale <= stale_now;
      res_q.tag   <= cpl_valid ? cpl_tag : '0;
      if (fatal_next) begin
        open_q <= '0;
        drop_q <= drop_view;
        if (stale_now) drop_q[cpl_tag] <= 1'b0;
      end else begin
        if (fwd_now) open_q[cpl_tag] <= 1'b0;
        if (req_valid && req_np) open_q[req_tag] <= 1'b1;
      end
    end
  end

  a_r8_no_fwd_when_fatal: assert property (@(posedge clk) disable iff (rst)
    fatal_q |-> !res_q.fwd);
  a_r6_fwd_needs_cpl: assert property (@(posedge clk) disable iff (rst)
    res_q.fwd |-> $past(cpl_valid));
  a_r7_fwd_drop_excl: assert property (@(posedge clk) disable iff (rst)
    !(res_q.fwd && res_q.drop));
  a_r9_stale_is_drop: assert property (@(posedge clk) disable iff (rst)
    res_q.stale |-> (res_q.drop && fatal_q));
  a_r8_open_empty: assert property (@(posedge clk) disable iff (rst)
    fatal_q |-> (open_q == '0));
endmodule

// File: rtl/link_fatal_guard.sv
module link_fatal_guard #(
  parameter int unsigned TAG_W     = lfg_pkg::TAG_W,
  parameter int unsigned WIDTH_W   = lfg_pkg::WIDTH_W,
  parameter int unsigned DEV_W     = lfg_pkg::DEV_W,
  parameter int unsigned REQ_LANES = 4,
  parameter int unsigned SERR_DEV  = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_up,
  input  logic [WIDTH_W-1:0] link_width,
  input  logic               serr_en,
  input  logic               req_valid,
  input  logic               req_np,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               cpl_valid,
  input  logic [TAG_W-1:0]   cpl_tag,
  output logic               retrain_block,
  output logic               fatal,
  output logic               width_bad,
  output logic               serr,
  output logic [DEV_W-1:0]   serr_dev,
  output logic               serr_status,
  output logic               cpl_fwd,
  output logic               cpl_drop,
  output logic               cpl_stale,
  output logic [TAG_W-1:0]   cpl_tag_o
);
  logic fatal_next, fatal_q;
  lfg_pkg::cpl_res_t res;

  lfg_link_monitor #(.WIDTH_W(WIDTH_W), .REQ_LANES(REQ_LANES)) u_mon (
    .clk(clk), .rst(rst), .link_up(link_up), .link_width(link_width),
    .serr_en(serr_en), .fatal_next(fatal_next), .fatal_q(fatal_q),
    .width_bad_q(width_bad), .serr_q(serr), .serr_status_q(serr_status)
  );

  lfg_tag_board #(.TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .fatal_next(fatal_next), .fatal_q(fatal_q),
    .req_valid(req_valid), .req_np(req_np), .req_tag(req_tag),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .res_q(res)
  );

  assign fatal         = fatal_q;
  assign retrain_block = fatal_q;
  assign serr_dev      = DEV_W'(SERR_DEV);
  assign cpl_fwd       = res.fwd;
  assign cpl_drop      = res.drop;
  assign cpl_stale     = res.stale;
  assign cpl_tag_o     = res.tag;

  a_r4_inhibit_follows: assert property (@(posedge clk) disable iff (rst)
    $rose(fatal) |-> retrain_block);
endmodule

// File: tb/sim_link_fatal_guard.sv
module sim_link_fatal_guard;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_up = 1'b0, serr_en = 1'b0, req_valid = 1'b0, req_np = 1'b0, cpl_valid = 1'b0;
  logic [4:0] link_width = 5'd0, req_tag = 5'd0, cpl_tag = 5'd0;
  logic retrain_block, fatal, width_bad, serr, serr_status, cpl_fwd, cpl_drop, cpl_stale;
  logic [4:0] serr_dev, cpl_tag_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_fatal_guard u0 (.*);

  bit m_open[32], m_drop[32];
  bit m_wasup, m_fatal, m_status;
  bit e_fatal, e_wbad, e_serr, e_status, e_fwd, e_drop, e_stale;
  logic [4:0] e_tag;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    foreach (m_open[i]) begin m_open[i] = 0; m_drop[i] = 0; end
    m_wasup = 0; m_fatal = 0; m_status = 0;
    e_fatal = 0; e_wbad = 0; e_serr = 0; e_status = 0;
    e_fwd = 0; e_drop = 0; e_stale = 0; e_tag = 0;
  endtask

  task automatic check_all();
    chk("R3", "fatal", 8'(fatal), 8'(e_fatal));
    chk("R4", "retrain_block", 8'(retrain_block), 8'(e_fatal));
    chk("R1", "width_bad", 8'(width_bad), 8'(e_wbad));
    chk("R5", "serr", 8'(serr), 8'(e_serr));
    chk("R5", "serr_status", 8'(serr_status), 8'(e_status));
    chk("R5", "serr_dev", 8'(serr_dev), 8'd0);
    chk("R6", "cpl_fwd", 8'(cpl_fwd), 8'(e_fwd));
    chk("R7_R8", "cpl_drop", 8'(cpl_drop), 8'(e_drop));
    chk("R9", "cpl_stale", 8'(cpl_stale), 8'(e_stale));
    chk("R6", "cpl_tag_o", 8'(cpl_tag_o), 8'(e_tag));
  endtask

  // Apply one cycle of inputs at negedge, predict outputs after the edge, check at next negedge.
  task automatic step(input bit lu, input logic [4:0] w, input bit se, input bit rv, input bit rnp,
                      input logic [4:0] rt, input bit cv, input logic [4:0] ct);
    bit ok, fn;
    link_up = lu; link_width = w; serr_en = se; req_valid = rv; req_np = rnp;
    req_tag = rt; cpl_valid = cv; cpl_tag = ct;
    ok = lu && (w == 5'd4);
    fn = m_fatal || (m_wasup && !lu);
    e_fwd   = cv && !fn && m_open[ct];
    e_drop  = cv && !e_fwd;
    e_stale = cv && fn && (m_fatal ? m_drop[ct] : m_open[ct]);
    e_tag   = cv ? ct : 5'd0;
    e_serr  = se && fn && !m_fatal;
    e_wbad  = lu && (w != 5'd4);
    if (fn) begin
      if (!m_fatal) foreach (m_open[i]) m_drop[i] = m_open[i];
      if (e_stale) m_drop[ct] = 0;
      foreach (m_open[i]) m_open[i] = 0;
    end else begin
      if (e_fwd) m_open[ct] = 0;
      if (rv && rnp) m_open[rt] = 1;
    end
    m_wasup = m_wasup || ok;
    m_fatal = fn;
    if (e_serr) m_status = 1;
    e_fatal = m_fatal; e_status = m_status;
    @(negedge clk);
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    link_up = 0; req_valid = 0; cpl_valid = 0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    model_reset();
    check_all(); // reset state
  endtask

  task automatic rnd_traffic(input int n, input bit lu, input logic [4:0] w, input bit se);
    for (int i = 0; i < n; i++)
      step(lu, w, se, ($urandom % 2) == 0, ($urandom % 4) != 0, 5'($urandom % 8),
           ($urandom % 2) == 0, 5'($urandom % 8));
  endtask

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    for (int trial = 0; trial < 8; trial++) begin
      do_reset();
      // R2: training flaps before first link-up are harmless
      for (int i = 0; i < 10; i++) step(i % 3 == 0, 5'd2, 1, 0, 0, 0, 0, 0);
      rnd_traffic(8, 0, 5'd4, 1);
      if (trial == 1) begin
        // R1: up at x8 then drop: not fatal
        rnd_traffic(20, 1, 5'd8, 1);
        rnd_traffic(20, 0, 5'd8, 1);
        continue;
      end
      rnd_traffic(150, 1, 5'd4, trial != 2);
      // R6/R7 directed: posted request does not open tag, non-posted does
      step(1, 5'd4, 1, 1, 0, 5'd20, 0, 0);
      step(1, 5'd4, 1, 0, 0, 0, 1, 5'd20);
      step(1, 5'd4, 1, 1, 1, 5'd21, 0, 0);
      step(1, 5'd4, 1, 1, 1, 5'd22, 0, 0);
      step(1, 5'd4, 1, 0, 0, 0, 1, 5'd21);
      // R3/R5/R8: drop with completion in the same cycle
      step(0, 5'd4, trial != 2, 0, 0, 0, trial == 3, 5'd22);
      // R9: completions for outstanding tags, twice each
      step(0, 5'd4, 1, 0, 0, 0, 1, 5'd22);
      step(0, 5'd4, 1, 0, 0, 0, 1, 5'd22);
      rnd_traffic(60, 0, 5'd4, 1);
      // R3: link returns, stays fatal
      rnd_traffic(60, 1, 5'd4, 1);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); total++; bad++;
        $display("FAIL watchdog timeout"); end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule